// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave on a four-wire serial link. It lets an external microcontroller read and write single bytes in an on-chip register file. An active-low select line frames each transfer, and it is the only way the device is chosen: no device address is sent. The master first sends one direction bit. A 1 asks for a read and a 0 asks for a write. A 15-bit address follows, most significant bit first, and only its low 11 bits are used. The last part is an 8-bit data phase, either write data on the serial input or read data returned on the serial output.

The link pins are sampled by the block's own clock through two-stage synchronizers, and the serial clock edges are detected in that clock domain. Toward the register file the block drives a simple register bus: an address, a write strobe with write data, a read strobe, and a read data return. The serial output has a separate enable, so the pad can place it in high impedance. The enable is set only while read data is being returned.

The serial clock high and low times must each last at least four periods of the block clock. The register file must present read data in the cycle that follows the read strobe.

Top module: `spi_reg_port`

## Requirements
- R1: After reset, and while select is high, `spi_sdo_oe`, `reg_wr` and `reg_rd` are all 0.
- R2: The first bit sampled on a rising serial clock edge after select falls sets the direction: 1 is a read and 0 is a write. A frame never produces both strobes.
- R3: The 15 address bits follow the direction bit, most significant bit first. `reg_addr` carries the last 11 of them. The first 4 address bits have no effect.
- R4: In a write frame, the 8 data bits follow the address, most significant bit first. Exactly one single-cycle `reg_wr` pulse, with `reg_wdata` equal to those bits, is issued after the 24th bit is sampled.
- R5: If select rises before the 24th bit of a write frame, no `reg_wr` is issued and the register file is unchanged.
- R6: In a read frame, exactly one single-cycle `reg_rd` pulse is issued after the last address bit. The byte on `reg_rdata` in the following cycle is shifted out on `spi_sdo`, most significant bit first. The first bit is driven after the falling serial clock edge that follows the last address bit, and each later bit is driven after the next falling edge.
- R7: `spi_sdo_oe` is 0 during the direction and address bits, throughout write frames, and within a few block clocks after select rises. It is 1 during the read data phase.
- R8: The serial input is ignored during the read data phase. The returned byte does not depend on it, and no write is issued.
- R9: Select going high clears the bit position. A frame cut short at any point is followed by a new frame that starts again at the direction bit.
- R10: Serial clock edges after the 24th bit are ignored until select rises, so no second write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sclk | input | 1 | Serial clock from master |
| spi_sdi | input | 1 | Serial data from master |
| spi_sdo | output | 1 | Serial read data to master |
| spi_sdo_oe | output | 1 | Output enable for the serial data pad |
| reg_addr | output | 11 | Register address |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |

## Verification
Random full-length reads and writes to random addresses, with random values in the ignored address bits, are compared against a shadow copy of the register file. These show whether the direction bit, the 11-bit address decode and the bit ordering in both directions are correct. Directed frames cut short at the direction bit, in the address and one bit before the end of the write data show that an incomplete write is dropped and that the next frame is framed correctly. Read frames with random input data during the data phase show that the input is ignored there, and over-long write frames show that trailing edges cause no second write. Each frame also checks the output enable before every rising edge, which separates the read data phase from every other phase.

// File: rtl/spi_reg_port.sv
module spi_reg_port #(
  parameter int ADDR_W    = 15,
  parameter int ADDR_USED = 11,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_cs_n,
  input  logic                 spi_sclk,
  input  logic                 spi_sdi,
  output logic                 spi_sdo,
  output logic                 spi_sdo_oe,
  output logic [ADDR_USED-1:0] reg_addr,
  output logic                 reg_wr,
  output logic [DATA_W-1:0]    reg_wdata,
  output logic                 reg_rd,
  input  logic [DATA_W-1:0]    reg_rdata
);

  localparam int HDR   = 1 + ADDR_W;
  localparam int FRAME = HDR + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam int SH_W  = (ADDR_USED > DATA_W) ? ADDR_USED : DATA_W;

  logic cs_m, cs_s;
  logic sclk_m, sclk_s, sclk_q;
  logic sdi_m, sdi_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_m   <= 1'b1;
      cs_s   <= 1'b1;
      sclk_m <= 1'b0;
      sclk_s <= 1'b0;
      sclk_q <= 1'b0;
      sdi_m  <= 1'b0;
      sdi_s  <= 1'b0;
    end else begin
      cs_m   <= spi_cs_n;
      cs_s   <= cs_m;
      sclk_m <= spi_sclk;
      sclk_s <= sclk_m;
      sclk_q <= sclk_s;
      sdi_m  <= spi_sdi;
      sdi_s  <= sdi_m;
    end
  end

  wire rise = sclk_s & ~sclk_q & ~cs_s;
  wire fall = ~sclk_s & sclk_q & ~cs_s;

  logic [CNT_W-1:0]  bitcnt;
  logic [SH_W-2:0]   sreg;
  logic [DATA_W-1:0] tx;
  logic              is_rd, rd_d, sdo_q, oe_q;

  wire in_frame  = bitcnt < CNT_W'(FRAME);
  wire last_addr = bitcnt == CNT_W'(HDR - 1);
  wire last_data = bitcnt == CNT_W'(FRAME - 1);
  wire rd_phase  = is_rd && (bitcnt >= CNT_W'(HDR)) && in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt    <= '0;
      sreg      <= '0;
      tx        <= '0;
      is_rd     <= 1'b0;
      rd_d      <= 1'b0;
      sdo_q     <= 1'b0;
      oe_q      <= 1'b0;
      reg_addr  <= '0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      reg_rd    <= 1'b0;
    end else if (cs_s) begin
      bitcnt <= '0;
      is_rd  <= 1'b0;
      rd_d   <= 1'b0;
      oe_q   <= 1'b0;
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      rd_d   <= reg_rd;
      if (rise && in_frame) begin
        bitcnt <= bitcnt + 1'b1;
        sreg   <= {sreg[SH_W-3:0], sdi_s};
        if (bitcnt == '0) is_rd <= sdi_s;
        if (last_addr) begin
          reg_addr <= {sreg[ADDR_USED-2:0], sdi_s};
          reg_rd   <= is_rd;
        end
        if (last_data && !is_rd) begin
          reg_wr    <= 1'b1;
          reg_wdata <= {sreg[DATA_W-2:0], sdi_s};
        end
      end
      if (rd_d) tx <= reg_rdata;
      if (fall && rd_phase) begin
        sdo_q <= tx[DATA_W-1];
        tx    <= {tx[DATA_W-2:0], 1'b0};
        oe_q  <= 1'b1;
      end
    end
  end

  assign spi_sdo    = sdo_q;
  assign spi_sdo_oe = oe_q;

endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic reg_wr,
  input logic reg_rd,
  input logic sdo_oe
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!reg_wr && !reg_rd));

  a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  a_r5_wr_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !$past(cs_s));

  a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  a_r7_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !sdo_oe);

  a_r8_no_wr_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> !reg_wr);

endmodule

bind spi_reg_port spi_reg_port_chk i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_s   (cs_s),
  .reg_wr (reg_wr),
  .reg_rd (reg_rd),
  .sdo_oe (spi_sdo_oe)
);

// File: tb/test_spi_reg_port.sv
module test_spi_reg_port;

  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic        sdo, sdo_oe, reg_wr, reg_rd;
  logic [10:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;

  always #4 clk = ~clk;

  spi_reg_port i_spi_reg_port (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  logic [7:0]  mem [2048];
  logic [7:0]  shadow [2048];
  int          wr_cnt = 0, rd_cnt = 0;
  logic [10:0] last_a;
  logic [7:0]  last_d;
  int          checks = 0, errors = 0;
  bit          done = 0;

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 37 + 5) ^ 8'(i >> 3);
  endfunction

  initial begin
    for (int i = 0; i < 2048; i++) begin
      mem[i] = init_val(i);
      shadow[i] = init_val(i);
    end
  end

  always @(posedge clk) begin
    if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
      wr_cnt <= wr_cnt + 1;
      last_a <= reg_addr;
      last_d <= reg_wdata;
    end
    if (reg_rd) begin
      reg_rdata <= mem[reg_addr];
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit rd, input logic [14:0] a, input logic [7:0] d,
                      input int nb, input bit rnd_sdi,
                      output logic [7:0] rx, output bit oe_bad);
    logic [23:0] fr;
    fr = {rd, a, d};
    rx = '0;
    oe_bad = 0;
    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < nb; i++) begin
      if (i < 24) sdi = fr[23-i];
      else sdi = 1'($urandom);
      if (rd && i >= 16 && rnd_sdi) sdi = 1'($urandom);
      repeat (H) @(negedge clk);
      if (sdo_oe !== (rd && i >= 16)) oe_bad = 1;
      if (rd && i >= 16 && i < 24) rx[23-i] = sdo;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * H) @(negedge clk);
  endtask

  task automatic do_write(input logic [14:0] a, input logic [7:0] d, input int nb, input string tag);
    int w0;
    logic [7:0] rx;
    bit ob;
    w0 = wr_cnt;
    xfer(1'b0, a, d, nb, 1'b0, rx, ob);
    chk({tag, " R7 oe during write"}, ob, 0);
    if (nb >= 24) begin
      shadow[a[10:0]] = d;
      chk({tag, " R4 one write pulse"}, wr_cnt - w0, 1);
      chk({tag, " R3 write address"}, last_a, a[10:0]);
      chk({tag, " R4 write data"}, last_d, d);
    end else begin
      chk({tag, " R5 aborted write"}, wr_cnt - w0, 0);
    end
  endtask

  task automatic do_read(input logic [14:0] a, input bit rnd, input string tag);
    int w0, r0;
    logic [7:0] rx;
    bit ob;
    w0 = wr_cnt;
    r0 = rd_cnt;
    xfer(1'b1, a, 8'h00, 24, rnd, rx, ob);
    chk({tag, " R6 read data"}, rx, shadow[a[10:0]]);
    chk({tag, " R6 one read pulse"}, rd_cnt - r0, 1);
    chk({tag, " R8 no write in read"}, wr_cnt - w0, 0);
    chk({tag, " R7 oe during read"}, ob, 0);
  endtask

  initial begin
    logic [7:0] rx;
    bit ob;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    chk("R1 oe after reset", sdo_oe, 0);
    chk("R1 wr after reset", reg_wr, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe idle", sdo_oe, 0);
    chk("R1 rd idle", reg_rd, 0);

    do_write(15'h0123, 8'hA5, 24, "dir");
    do_read(15'h0123, 0, "dir");
    do_write(15'h7800 | 15'h055, 8'h3C, 24, "hi");
    do_read(15'h0055, 0, "hi R3");
    do_read(15'h2055, 0, "hi2 R3");
    do_write(15'h07FF, 8'hFF, 24, "edge");
    do_read(15'h07FF, 1, "edge R8");
    do_write(15'h0000, 8'h00, 24, "zero");
    do_read(15'h0000, 1, "zero");

    do_write(15'h0200, 8'h99, 1, "cut1 R9");
    do_write(15'h0200, 8'h99, 10, "cut10 R9");
    do_write(15'h0200, 8'h99, 23, "cut23");
    do_read(15'h0200, 0, "cut R5");
    chk("R7 oe after cs high", sdo_oe, 0);
    xfer(1'b1, 15'h0201, 8'h0, 12, 1'b0, rx, ob);
    do_write(15'h0201, 8'h5A, 24, "after-rd-cut R9");
    do_read(15'h0201, 0, "after-rd-cut");

    do_write(15'h0300, 8'hC3, 32, "long R10");
    do_read(15'h0300, 0, "long R10");

    for (int n = 0; n < 40; n++) begin
      logic [14:0] a;
      logic [7:0]  d;
      a = 15'($urandom);
      d = 8'($urandom);
      if ($urandom % 2 == 0) do_write(a, d, 24, "rnd R2");
      else do_read(a, 1'($urandom), "rnd R2");
    end

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule